// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

A binary counter whose every state change is taken on the rising clock edge. A synchronous parallel load presets the count from an input word. Counting goes up or down under a direction select and needs two active-low enables. The load has priority over counting. The counter has no reset, so the first load sets its known state.

The terminal-count flag is active low and combinational. It is gated by the trickle enable but never by the parallel enable. Chaining works as follows. All stages share the clock, the load control, the direction and the parallel enable. The lowest stage's trickle enable is the global enable, and each higher stage's trickle enable is the terminal count of the stage below. A carry or borrow therefore ripples through the chain within one clock cycle.

Top module: `cud_counter`

## Requirements
- R1: While `load_n` is 0, each rising clock edge copies `din` into `q`, whatever the levels of `en_par_n`, `en_trk_n` and `up`.
- R2: While `load_n` is 1, `en_par_n` is 0, `en_trk_n` is 0 and `up` is 1, each rising edge adds one to `q`.
- R3: While `load_n` is 1, `en_par_n` is 0, `en_trk_n` is 0 and `up` is 0, each rising edge subtracts one from `q`.
- R4: While `load_n` is 1 and either `en_par_n` or `en_trk_n` is 1, `q` keeps its value across the edge.
- R5: Counting is modulo 2^WIDTH. With WIDTH = 4, counting up goes from 15 to 0 and counting down goes from 0 to 15.
- R6: `tc_n` is 0 exactly when `en_trk_n` is 0 and either `up` is 1 with `q` all ones, or `up` is 0 with `q` all zeros. Otherwise it is 1.
- R7: `tc_n` does not depend on `en_par_n`. It follows `q`, `up` and `en_trk_n` in the same cycle, with no clock edge between.
- R8: In a chain where each higher stage's `en_trk_n` is the `tc_n` of the stage below, the stages together form one counter of the combined width. That counter counts up and down with wrap, and it holds while the lowest stage's `en_trk_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel preset value |
| en_par_n | input | 1 | Active-low count enable, not seen by `tc_n` |
| en_trk_n | input | 1 | Active-low count enable that also gates `tc_n` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | WIDTH | Current count |
| tc_n | output | 1 | Active-low terminal count |

## Verification
The bench builds the counter with WIDTH = 4, so all 16 count values can be swept. Every start value is combined with all eight settings of the two enables and the direction. This covers every load, increment, decrement, hold and terminal-count case, including both wrap points. Two more 4-bit instances are chained into an 8-bit counter. Runs across 255 to 0 and 0 to 255 show the carry and borrow passing between the stages within one cycle.

// File: rtl/cud_pkg.sv
`timescale 1ns/1ps
package cud_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_INC  = 2'd2,
        MODE_DEC  = 2'd3
    } mode_e;

    typedef struct packed {
        logic load_n;
        logic en_par_n;
        logic en_trk_n;
        logic up;
    } ctl_t;

    // Load wins over counting; counting needs both enables asserted (low).
    function automatic mode_e pick_mode(input ctl_t c);
        mode_e m;
        if (!c.load_n)
            m = MODE_LOAD;
        else if (!c.en_par_n && !c.en_trk_n)
            m = c.up ? MODE_INC : MODE_DEC;
        else
            m = MODE_HOLD;
        return m;
    endfunction

endpackage

// File: rtl/cud_mode_sel.sv
`timescale 1ns/1ps
module cud_mode_sel
    import cud_pkg::*;
(
    input  ctl_t  ctl,
    output mode_e mode
);
    always_comb begin
        mode = pick_mode(ctl);
    end
endmodule

// File: rtl/cud_next.sv
`timescale 1ns/1ps
module cud_next
    import cud_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e            mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode)
            MODE_LOAD: nxt = din;
            MODE_INC:  nxt = cur + ONE;
            MODE_DEC:  nxt = cur - ONE;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/cud_term.sv
`timescale 1ns/1ps
module cud_term #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             en_trk_n,
    output logic             tc_n
);
    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &cur;
        at_bottom = ~|cur;
        tc_n      = ~(~en_trk_n & (up ? at_top : at_bottom));
    end

    // R6: terminal count may only be asserted while the trickle enable is asserted
    p_tc_gated_r6: assert property (@(posedge clk) !tc_n |-> !en_trk_n);
endmodule

// File: rtl/cud_counter.sv
`timescale 1ns/1ps
module cud_counter
    import cud_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par_n,
    input  logic             en_trk_n,
    input  logic             up,
    output logic [WIDTH-1:0] q,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    ctl_t             ctl;
    mode_e            mode;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    assign ctl = '{load_n: load_n, en_par_n: en_par_n, en_trk_n: en_trk_n, up: up};

    cud_mode_sel u_mode (
        .ctl  (ctl),
        .mode (mode)
    );

    cud_next #(.WIDTH(WIDTH)) u_next (
        .mode (mode),
        .cur  (cnt_q),
        .din  (din),
        .nxt  (cnt_d)
    );

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    cud_term #(.WIDTH(WIDTH)) u_term (
        .clk      (clk),
        .cur      (cnt_q),
        .up       (up),
        .en_trk_n (en_trk_n),
        .tc_n     (tc_n)
    );

    assign q = cnt_q;

    // R1: a load takes the data word on the next edge
    p_load_r1: assert property (@(posedge clk) !load_n |=> q == $past(din));
    // R2: enabled up-count adds one
    p_inc_r2: assert property (@(posedge clk)
        load_n && !en_par_n && !en_trk_n && up |=> q == $past(q) + ONE);
    // R3: enabled down-count subtracts one
    p_dec_r3: assert property (@(posedge clk)
        load_n && !en_par_n && !en_trk_n && !up |=> q == $past(q) - ONE);
    // R4: any deasserted enable holds the count
    p_hold_r4: assert property (@(posedge clk)
        load_n && (en_par_n || en_trk_n) |=> $stable(q));
    // R5: wrap from all ones to zero when counting up
    p_wrap_r5: assert property (@(posedge clk)
        load_n && !en_par_n && !en_trk_n && up && (&q) |=> q == '0);
endmodule

// File: tb/cud_counter_tb.sv
`timescale 1ns/1ps
module cud_counter_tb;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // single stage
    logic         load_n = 1'b0;
    logic [W-1:0] din    = '0;
    logic         par_n  = 1'b1;
    logic         trk_n  = 1'b1;
    logic         up     = 1'b1;
    logic [W-1:0] q;
    logic         tc_n;

    cud_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .load_n(load_n), .din(din), .en_par_n(par_n),
        .en_trk_n(trk_n), .up(up), .q(q), .tc_n(tc_n)
    );

    // two-stage chain
    logic         c_load_n = 1'b0;
    logic [7:0]   c_din    = '0;
    logic         c_par_n  = 1'b1;
    logic         c_trk_n  = 1'b1;
    logic         c_up     = 1'b1;
    logic [W-1:0] lo_q, hi_q;
    logic         lo_tc_n, hi_tc_n;

    cud_counter #(.WIDTH(W)) u_lo (
        .clk(clk), .load_n(c_load_n), .din(c_din[3:0]), .en_par_n(c_par_n),
        .en_trk_n(c_trk_n), .up(c_up), .q(lo_q), .tc_n(lo_tc_n)
    );
    cud_counter #(.WIDTH(W)) u_hi (
        .clk(clk), .load_n(c_load_n), .din(c_din[7:4]), .en_par_n(c_par_n),
        .en_trk_n(lo_tc_n), .up(c_up), .q(hi_q), .tc_n(hi_tc_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input bit ld, input int d, input bit p, input bit t, input bit u);
        @(negedge clk);
        load_n = ld; din = W'(d); par_n = p; trk_n = t; up = u;
    endtask

    task automatic preset(input int v);
        drive(1'b0, v, 1'b1, 1'b1, 1'b1);
        edge_wait();
    endtask

    task automatic c_step(input bit p, input bit t, input bit u, inout int exp);
        @(negedge clk);
        c_load_n = 1'b1; c_par_n = p; c_trk_n = t; c_up = u;
        edge_wait();
        if (!p && !t) exp = u ? (exp + 1) % 256 : (exp + 255) % 256;
        chk({hi_q, lo_q} == 8'(exp), "R8 chain count", {hi_q, lo_q}, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int e;
        // Known state through a load (no reset on this block)
        edge_wait();
        chk(q == '0, "R1 initial load", q, 0);

        // R1: load for every value and every control setting
        for (int v = 0; v < M; v++) begin
            for (int c = 0; c < 8; c++) begin
                drive(1'b0, v, c[2], c[1], c[0]);
                edge_wait();
                chk(q == W'(v), "R1 load priority", q, v);
            end
        end

        // R2/R3/R4/R5: one step from every start under every control setting
        for (int s = 0; s < M; s++) begin
            for (int c = 0; c < 8; c++) begin
                preset(s);
                drive(1'b1, (s + 7) % M, c[2], c[1], c[0]);
                edge_wait();
                if (c[2] || c[1]) begin
                    chk(q == W'(s), "R4 hold", q, s);
                end else if (c[0]) begin
                    e = (s + 1) % M;
                    chk(q == W'(e), (s == M - 1) ? "R5 up wrap" : "R2 increment", q, e);
                end else begin
                    e = (s + M - 1) % M;
                    chk(q == W'(e), (s == 0) ? "R5 down wrap" : "R3 decrement", q, e);
                end
            end
        end

        // R6/R7: terminal count, combinational, independent of parallel enable
        for (int s = 0; s < M; s++) begin
            preset(s);
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                load_n = 1'b1; par_n = 1'b1; trk_n = c[1]; up = c[0];
                par_n = c[2];
                #1;
                e = (!c[1] && ((c[0] && s == M - 1) || (!c[0] && s == 0))) ? 0 : 1;
                chk(tc_n == e[0], c[2] ? "R7 tc ignores par enable" : "R6 terminal count",
                    tc_n, e);
                par_n = 1'b1; trk_n = 1'b1;
            end
        end

        // R8: chained 8-bit counter through the carry and borrow
        @(negedge clk);
        c_load_n = 1'b0; c_din = 8'd250;
        edge_wait();
        e = 250;
        chk({hi_q, lo_q} == 8'd250, "R8 chain load", {hi_q, lo_q}, 250);
        for (int i = 0; i < 20; i++) c_step(1'b0, 1'b0, 1'b1, e);
        for (int i = 0; i < 3; i++)  c_step(1'b0, 1'b1, 1'b1, e);
        for (int i = 0; i < 3; i++)  c_step(1'b1, 1'b0, 1'b1, e);
        for (int i = 0; i < 40; i++) c_step(1'b0, 1'b0, 1'b0, e);
        @(negedge clk);
        c_load_n = 1'b0; c_din = 8'd15;
        edge_wait();
        e = 15;
        c_step(1'b0, 1'b0, 1'b1, e);
        c_step(1'b0, 1'b0, 1'b0, e);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule